// File: doc/BRIEF.md
# Pipelined Binary-Field Inverter

This block returns the multiplicative inverse of an element of GF(2^M), where each element is an M-bit polynomial-basis vector, and M is 8 by default. The inverse is the power A^(2^M − 2). The block builds it as a fixed chain of steps that square first and then multiply: the partial result B starts as the operand A, and each step replaces it with A·B². After M−2 steps B has reached A^(2^(M−1) − 1). One more squaring then gives the inverse. Each step pairs a bit-parallel squarer with a multiplier that has one register per multiplier bit, so every step takes M cycles. The final squaring is padded to M cycles as well. The total latency is therefore M·(M−1) cycles, which is 56 for the default build.

Each operand moves down the pipeline with its own copy of A and its own valid bit. A new operand can be presented on every clock, and results come out in the order the operands went in, one per clock. There is no backpressure. The consumer must accept a result in the cycle it is presented. An operand of zero yields zero. A synchronous reset clears every valid bit, so no operand that was in flight at the reset produces a result.

Top module: `gf_inverter`

## Requirements
- R1: While reset is held, and in every cycle after it until an operand arrives, `out_valid` is 0.
- R2: An operand sampled with `in_valid` = 1 at a rising clock edge appears on `out_data`, with `out_valid` = 1, after exactly M·(M−1) rising edges. For M = 8 this is 56 edges.
- R3: For a nonzero operand, the product of the result and the operand is 1. The product is taken modulo the field polynomial x^M plus the lower terms given by `POLY`. The default `POLY` is 8'h1B, which gives x^8+x^4+x^3+x+1.
- R4: An operand of zero produces a result of zero.
- R5: Operands presented on consecutive cycles give results on consecutive cycles, in the same order, with no cycle lost.
- R6: A cycle with `in_valid` = 0 produces no result, whatever value `in_data` holds, and it leaves a gap at the same position in the output stream.
- R7: A synchronous reset asserted while operands are in flight discards all of them: none of them ever raises `out_valid`. Operands presented after the reset are processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all valid bits |
| in_valid | input | 1 | Operand strobe |
| in_data | input | M | Operand in polynomial basis |
| out_valid | output | 1 | Result strobe |
| out_data | output | M | Inverse of the operand that entered M·(M−1) cycles earlier |

## Verification
The bench builds the block with M = 8 and the polynomial 8'h1B. With these values all 256 field elements can be covered. Every nonzero element is streamed on back-to-back cycles, and each result is compared with an inverse found by exhaustive search. The product of each result and its operand is also confirmed to be 1. At this size the 56-cycle latency can be measured exactly for each result, and a reset can be applied while the pipeline is still filling, so that the flush can be observed before the pipeline has drained.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

   // Number of square-then-multiply steps needed before the final squaring.
   function automatic int unsigned gfinv_steps(input int unsigned m);
      return m - 2;
   endfunction

   // Total pipeline depth: (m-2) steps of m stages plus an m-stage tail.
   function automatic int unsigned gfinv_latency(input int unsigned m);
      return m * (m - 1);
   endfunction

   // Placement of the squarer inside the tail stage.
   typedef enum logic {
      TAIL_SQ_FRONT = 1'b0,
      TAIL_SQ_BACK  = 1'b1
   } tail_sq_place_e;

endpackage

// File: rtl/gfinv_squarer.sv
module gfinv_squarer #(
   parameter int unsigned M    = 8,
   parameter logic [M-1:0] POLY = 8'h1B
) (
   input  logic [M-1:0] a_i,
   output logic [M-1:0] sq_o
);
   localparam int unsigned WIDE = 2 * M - 1;

   logic [WIDE-1:0] spread;
   logic [WIDE-1:0] folded;
   logic [WIDE-1:0] poly_wide;

   assign poly_wide = {{(M - 1){1'b0}}, POLY};

   // Squaring in characteristic two only spreads the bits apart.
   always_comb begin
      spread = '0;
      for (int i = 0; i < M; i++) begin
         spread[2 * i] = a_i[i];
      end
   end

   // Fold the high terms back, working from the top term downward.
   always_comb begin
      folded = spread;
      for (int k = WIDE - 1; k >= M; k--) begin
         if (folded[k]) begin
            folded    = folded ^ (poly_wide << (k - M));
            folded[k] = 1'b0;
         end
      end
   end

   assign sq_o = folded[M-1:0];

endmodule

// File: rtl/gfinv_mul_cell.sv
module gfinv_mul_cell #(
   parameter int unsigned M    = 8,
   parameter logic [M-1:0] POLY = 8'h1B
) (
   input  logic [M-1:0] acc_i,
   input  logic [M-1:0] mcand_i,
   input  logic         bit_i,
   output logic [M-1:0] acc_o
);
   logic [M-1:0] shifted;

   // Multiply the accumulator by x, then add the partial product for this bit.
   assign shifted = {acc_i[M-2:0], 1'b0} ^ (acc_i[M-1] ? POLY : '0);
   assign acc_o   = shifted ^ (bit_i ? mcand_i : '0);

endmodule

// File: rtl/gfinv_step.sv
module gfinv_step #(
   parameter int unsigned M    = 8,
   parameter logic [M-1:0] POLY = 8'h1B
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         v_i,
   input  logic [M-1:0] a_i,
   input  logic [M-1:0] b_i,
   output logic         v_o,
   output logic [M-1:0] a_o,
   output logic [M-1:0] p_o
);
   // One register stage per bit of the squared multiplier, taken MSB first.
   logic [M-1:0] sq_in;
   logic [M-1:0] acc_q [M];
   logic [M-1:0] opa_q [M];
   logic [M-1:0] sqv_q [M];
   logic [M-1:0] vld_q;
   logic [M-1:0] acc_d [M];

   gfinv_squarer #(.M(M), .POLY(POLY)) u_sq (
      .a_i  (b_i),
      .sq_o (sq_in)
   );

   for (genvar k = 0; k < M; k++) begin : g_stage
      logic [M-1:0] src_acc;
      logic [M-1:0] src_opa;
      logic [M-1:0] src_sq;
      if (k == 0) begin : g_head
         assign src_acc = '0;
         assign src_opa = a_i;
         assign src_sq  = sq_in;
      end else begin : g_body
         assign src_acc = acc_q[k-1];
         assign src_opa = opa_q[k-1];
         assign src_sq  = sqv_q[k-1];
      end
      gfinv_mul_cell #(.M(M), .POLY(POLY)) u_cell (
         .acc_i   (src_acc),
         .mcand_i (src_opa),
         .bit_i   (src_sq[M-1-k]),
         .acc_o   (acc_d[k])
      );
   end

   always_ff @(posedge clk) begin
      acc_q[0] <= acc_d[0];
      opa_q[0] <= a_i;
      sqv_q[0] <= sq_in;
      for (int k = 1; k < M; k++) begin
         acc_q[k] <= acc_d[k];
         opa_q[k] <= opa_q[k-1];
         sqv_q[k] <= sqv_q[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else begin
         vld_q <= {vld_q[M-2:0], v_i};
      end
   end

   assign v_o = vld_q[M-1];
   assign a_o = opa_q[M-1];
   assign p_o = acc_q[M-1];

endmodule

// File: rtl/gfinv_tail.sv
module gfinv_tail
   import gfinv_pkg::*;
#(
   parameter int unsigned   M     = 8,
   parameter logic [M-1:0]  POLY  = 8'h1B,
   parameter int unsigned   DEPTH = 8,
   parameter tail_sq_place_e PLACE = TAIL_SQ_FRONT
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         v_i,
   input  logic [M-1:0] b_i,
   output logic         v_o,
   output logic [M-1:0] r_o
);
   logic [M-1:0] sq_src;
   logic [M-1:0] sq_res;
   logic [M-1:0] pad_in;
   logic [M-1:0] pad_out;

   gfinv_squarer #(.M(M), .POLY(POLY)) u_sq (
      .a_i  (sq_src),
      .sq_o (sq_res)
   );

   if (PLACE == TAIL_SQ_FRONT) begin : g_front
      assign sq_src = b_i;
      assign pad_in = sq_res;
      assign r_o    = pad_out;
   end else begin : g_back
      assign pad_in = b_i;
      assign sq_src = pad_out;
      assign r_o    = sq_res;
   end

   if (DEPTH == 0) begin : g_none
      assign pad_out = pad_in;
      assign v_o     = v_i;
   end else begin : g_pad
      logic [M-1:0] dat_q [DEPTH];
      logic [DEPTH-1:0] vld_q;

      always_ff @(posedge clk) begin
         dat_q[0] <= pad_in;
         for (int k = 1; k < DEPTH; k++) begin
            dat_q[k] <= dat_q[k-1];
         end
      end

      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= v_i;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= {vld_q[DEPTH-2:0], v_i};
         end
      end

      assign pad_out = dat_q[DEPTH-1];
      assign v_o     = vld_q[DEPTH-1];
   end

endmodule

// File: rtl/gf_inverter.sv
module gf_inverter
   import gfinv_pkg::*;
#(
   parameter int unsigned    M     = 8,
   parameter logic [M-1:0]   POLY  = 8'h1B,
   parameter tail_sq_place_e PLACE = TAIL_SQ_FRONT
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [M-1:0] in_data,
   output logic         out_valid,
   output logic [M-1:0] out_data
);
   localparam int unsigned STEPS = gfinv_steps(M);
   localparam int unsigned LAT   = gfinv_latency(M);

   if (M < 3) begin : g_bad_width
      $error("gf_inverter: M must be at least 3");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf_inverter: field polynomial needs a constant term");
   end
   if (LAT != STEPS * M + M) begin : g_bad_depth
      $error("gf_inverter: stage depths do not add up to the latency");
   end

   logic         v_lnk [STEPS+1];
   logic [M-1:0] a_lnk [STEPS+1];
   logic [M-1:0] b_lnk [STEPS+1];

   // The running power starts as the operand itself.
   assign v_lnk[0] = in_valid;
   assign a_lnk[0] = in_data;
   assign b_lnk[0] = in_data;

   for (genvar s = 0; s < STEPS; s++) begin : g_chain
      gfinv_step #(.M(M), .POLY(POLY)) u_step (
         .clk (clk),
         .rst (rst),
         .v_i (v_lnk[s]),
         .a_i (a_lnk[s]),
         .b_i (b_lnk[s]),
         .v_o (v_lnk[s+1]),
         .a_o (a_lnk[s+1]),
         .p_o (b_lnk[s+1])
      );
   end

   gfinv_tail #(.M(M), .POLY(POLY), .DEPTH(M), .PLACE(PLACE)) u_tail (
      .clk (clk),
      .rst (rst),
      .v_i (v_lnk[STEPS]),
      .b_i (b_lnk[STEPS]),
      .v_o (out_valid),
      .r_o (out_data)
   );

endmodule

// File: rtl/gf_inverter_chk.sv
module gf_inverter_chk #(
   parameter int unsigned  M    = 8,
   parameter logic [M-1:0] POLY = 8'h1B
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [M-1:0] in_data,
   input logic         out_valid,
   input logic [M-1:0] out_data
);
   localparam int unsigned LAT = M * (M - 1);

   // Independent product, low bit of the multiplier first.
   function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y);
      logic [M-1:0] r;
      logic [M-1:0] t;
      r = '0;
      t = x;
      for (int i = 0; i < M; i++) begin
         if (y[i]) r = r ^ t;
         t = t[M-1] ? ({t[M-2:0], 1'b0} ^ POLY) : {t[M-2:0], 1'b0};
      end
      return r;
   endfunction

   // Window of the last LAT operands, held as a counter-free shift record.
   logic [LAT-1:0] win_v;
   logic [M-1:0]   win_d [LAT];

   always_ff @(posedge clk) begin
      if (rst) win_v <= '0;
      else     win_v <= {win_v[LAT-2:0], in_valid};
   end

   always_ff @(posedge clk) begin
      win_d[0] <= in_data;
      for (int k = 1; k < LAT; k++) win_d[k] <= win_d[k-1];
   end

   // R1 and R7: the first cycle after a reset shows no result.
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

   // R2, R5 and R6: the result strobe tracks the operand strobe exactly LAT edges later.
   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      out_valid == win_v[LAT-1]);

   // R3: a nonzero operand times its result gives one.
   a_r3_inverse: assert property (@(posedge clk) disable iff (rst)
      (out_valid && win_d[LAT-1] != '0) |-> (fmul(out_data, win_d[LAT-1]) == {{(M-1){1'b0}}, 1'b1}));

   // R4: zero maps to zero.
   a_r4_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && win_d[LAT-1] == '0) |-> (out_data == '0));

endmodule

bind gf_inverter gf_inverter_chk #(.M(M), .POLY(POLY)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_gf_inverter.sv
module sim_gf_inverter;
   localparam int CLK_PERIOD = 10;
   localparam int M   = 8;
   localparam int LAT = 56;
   localparam int QN  = 2048;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [M-1:0] in_data = '0;
   logic         out_valid;
   logic [M-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int wr = 0;
   int rd = 0;
   int seen = 0;
   logic [M-1:0] e_op  [QN];
   int           e_cyc [QN];

   gf_inverter #(.M(M), .POLY(8'h1B)) u0 (
      .clk, .rst, .in_valid, .in_data, .out_valid, .out_data
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] bmul(input logic [7:0] x, input logic [7:0] y);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
      for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h11B << (k - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] ref_inv(input logic [7:0] x);
      if (x == 8'h00) return 8'h00;
      for (int y = 1; y < 256; y++) if (bmul(x, 8'(y)) == 8'h01) return 8'(y);
      return 8'h00;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Scoreboard: every result is matched to the oldest pending operand.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         seen++;
         if (rd == wr) begin
            chk(1'b0, "R6 unexpected result", int'(out_data), -1);
         end else begin
            chk(cyc == e_cyc[rd], "R2 latency", cyc, e_cyc[rd]);
            if (e_op[rd] == 8'h00) begin
               chk(out_data == 8'h00, "R4 zero operand", int'(out_data), 0);
            end else begin
               chk(out_data == ref_inv(e_op[rd]), "R3 inverse", int'(out_data), int'(ref_inv(e_op[rd])));
               chk(bmul(out_data, e_op[rd]) == 8'h01, "R3 product", int'(bmul(out_data, e_op[rd])), 1);
            end
            rd++;
         end
      end
   end

   task automatic push(input logic [7:0] x);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      e_op[wr]  = x;
      e_cyc[wr] = cyc + LAT;
      wr++;
   endtask

   task automatic idle(input int n, input logic [7:0] junk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = junk ^ 8'(i);
      end
   endtask

   task automatic drain(input string req);
      idle(LAT + 4, 8'h5A);
      chk(rd == wr, req, rd, wr);
   endtask

   task automatic t_reset_state;
      int hits = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (out_valid) hits++;
      end
      rst = 1'b0;
      for (int i = 0; i < LAT + 8; i++) begin
         @(negedge clk);
         if (out_valid) hits++;
      end
      chk(hits == 0, "R1 idle after reset", hits, 0);
   endtask

   task automatic t_back_to_back;
      int s0 = seen;
      for (int x = 1; x < 256; x++) push(8'(x));
      drain("R5 all back-to-back results");
      chk(seen - s0 == 255, "R5 result count", seen - s0, 255);
   endtask

   task automatic t_zero;
      push(8'h00);
      push(8'h01);
      push(8'h00);
      push(8'h80);
      drain("R4 zero sequence drained");
   endtask

   task automatic t_gaps;
      int s0 = seen;
      for (int i = 0; i < 20; i++) begin
         push(8'(8'h11 * i + 3));
         idle(i % 3, 8'hC3);
      end
      drain("R6 gapped stream drained");
      chk(seen - s0 == 20, "R6 result count", seen - s0, 20);
   endtask

   task automatic t_reset_flush;
      int s0;
      for (int i = 0; i < 10; i++) push(8'(8'h1D + i));
      idle(20, 8'h0F);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      rd = wr;
      @(negedge clk);
      rst = 1'b0;
      s0 = seen;
      idle(LAT + 8, 8'hA5);
      chk(seen == s0, "R7 flushed operands silent", seen - s0, 0);
      push(8'h02);
      push(8'hFF);
      push(8'h53);
      drain("R7 operation after reset");
   endtask

   initial begin
      t_reset_state();
      t_back_to_back();
      t_zero();
      t_gaps();
      t_reset_flush();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule